// File: doc/BRIEF.md
# Converter Event Stream Parser

This block sits behind the readout of a 32-channel amplitude converter and turns its raw stream of 32-bit words into per-channel results. One word arrives per clock cycle, qualified by a valid input. A well-formed event is a header word that announces how many data words follow, the data words themselves, and a closing footer that carries the converter's running event counter. The block recognises each word by a three-bit type field, follows the expected order with a small state machine, and counts the data words it receives.

For every data word inside an event, the block pulses a result strobe carrying the channel number, the 12-bit measurement and the overflow and underflow flags. The footer produces an end-of-event strobe carrying the event counter. Three error strobes report a word that arrives out of order, a count that disagrees with the header, and the converter's invalid word. Nothing is stored beyond the event that is currently open.

Top module: `adc_evt_parser`

## Requirements
- R1: While reset is held and on the first cycle after it, every strobe output (res_valid, evt_done, err_seq, err_count, err_invalid) is low.
- R2: The word type is bits 26:24 of in_word: 010 is a header, 000 is data, 001 is a footer and 110 is the invalid word. Any other code is ignored: it produces no strobe and leaves the open event unchanged.
- R3: A data word inside an open event raises res_valid on the cycle after it is accepted. In that cycle res_chan is bits 20:16, res_value is bits 11:0, res_ovf is bit 12 and res_unf is bit 13 of that word.
- R4: A footer inside an open event raises evt_done on the cycle after it is accepted, with evt_count equal to its bits 23:0, and closes the event.
- R5: A data word or a footer that arrives while no event is open raises err_seq one cycle later. It produces neither res_valid nor evt_done.
- R6: When a footer closes an event and the number of data words received differs from the header's bits 13:8, err_count rises in the same cycle as evt_done. Too few and too many words are both flagged.
- R7: A header that arrives while an event is already open raises err_seq one cycle later. It then opens a new event with its own count, and data words received before it are not counted.
- R8: The invalid word raises err_invalid one cycle later and closes any open event without evt_done. A footer that follows it raises err_seq.
- R9: Cycles with in_valid low produce no strobe and do not disturb an open event.
- R10: The header count covers the whole field range. A header of count 0 followed directly by a footer closes cleanly, and a header of count 63 followed by 63 data words closes cleanly, both without err_count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | in_word holds a word this cycle |
| in_word | input | 32 | Word from the converter |
| res_valid | output | 1 | Per-channel result strobe |
| res_chan | output | 5 | Channel of the result |
| res_value | output | 12 | Measurement of the result |
| res_ovf | output | 1 | Overflow flag of the result |
| res_unf | output | 1 | Underflow flag of the result |
| evt_done | output | 1 | End-of-event strobe |
| evt_count | output | 24 | Event counter from the footer |
| err_seq | output | 1 | Word out of order |
| err_count | output | 1 | Data count disagrees with header |
| err_invalid | output | 1 | Invalid word received |

## Verification
Every strobe and field is registered once, so each result is due on the cycle after the edge that accepts its word, and on no other cycle. The bench drives each word on a falling edge. It samples the outputs shortly after the next rising edge, which is the one cycle of latency, and compares all five strobes on every word, so a strobe arriving early, late or twice is caught. Data fields and the event counter are compared only in the cycle in which their strobe is high.

// File: rtl/adc_evt_pkg.sv
package adc_evt_pkg;
    localparam int WORD_W = 32;
    localparam int TYPE_LO = 24;
    localparam int TYPE_W = 3;
    localparam int CNT_LO = 8;
    localparam int CNT_W = 6;
    localparam int CH_LO = 16;
    localparam int CH_W = 5;
    localparam int VAL_W = 12;
    localparam int OVF_BIT = 12;
    localparam int UNF_BIT = 13;
    localparam int EVC_W = 24;

    localparam logic [TYPE_W-1:0] T_HDR = 3'b010;
    localparam logic [TYPE_W-1:0] T_DATA = 3'b000;
    localparam logic [TYPE_W-1:0] T_FTR = 3'b001;
    localparam logic [TYPE_W-1:0] T_INV = 3'b110;

    typedef enum logic [2:0] {
        K_HDR,
        K_DATA,
        K_FTR,
        K_INV,
        K_OTHER
    } word_kind_t;

    typedef enum logic {
        S_IDLE,
        S_BODY
    } seq_state_t;
endpackage

// File: rtl/adc_word_classify.sv
module adc_word_classify
    import adc_evt_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output word_kind_t        kind,
    output logic [CNT_W-1:0]  hdr_count,
    output logic [CH_W-1:0]   chan,
    output logic [VAL_W-1:0]  value,
    output logic              ovf,
    output logic              unf,
    output logic [EVC_W-1:0]  evcount
);
    logic [TYPE_W-1:0] tcode;

    always_comb begin
        tcode = word[TYPE_LO +: TYPE_W];
        case (tcode)
            T_HDR:   kind = K_HDR;
            T_DATA:  kind = K_DATA;
            T_FTR:   kind = K_FTR;
            T_INV:   kind = K_INV;
            default: kind = K_OTHER;
        endcase
        hdr_count = word[CNT_LO +: CNT_W];
        chan      = word[CH_LO +: CH_W];
        value     = word[VAL_W-1:0];
        ovf       = word[OVF_BIT];
        unf       = word[UNF_BIT];
        evcount   = word[EVC_W-1:0];
    end
endmodule

// File: rtl/adc_evt_seq.sv
module adc_evt_seq
    import adc_evt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  word_kind_t       kind,
    input  logic [CNT_W-1:0] hdr_count,
    input  logic [CH_W-1:0]  chan,
    input  logic [VAL_W-1:0] value,
    input  logic             ovf,
    input  logic             unf,
    input  logic [EVC_W-1:0] evcount,
    output logic             res_valid,
    output logic [CH_W-1:0]  res_chan,
    output logic [VAL_W-1:0] res_value,
    output logic             res_ovf,
    output logic             res_unf,
    output logic             evt_done,
    output logic [EVC_W-1:0] evt_count,
    output logic             err_seq,
    output logic             err_count,
    output logic             err_invalid
);
    localparam int RCV_W = CNT_W + 1;
    localparam logic [RCV_W-1:0] RCV_MAX = {RCV_W{1'b1}};

    typedef struct packed {
        seq_state_t       state;
        logic [CNT_W-1:0] expect_n;
        logic [RCV_W-1:0] rcvd;
        logic             res_valid;
        logic [CH_W-1:0]  res_chan;
        logic [VAL_W-1:0] res_value;
        logic             res_ovf;
        logic             res_unf;
        logic             done;
        logic [EVC_W-1:0] evc;
        logic             e_seq;
        logic             e_cnt;
        logic             e_inv;
    } seq_t;

    seq_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.res_valid = 1'b0;
        st_d.done      = 1'b0;
        st_d.e_seq     = 1'b0;
        st_d.e_cnt     = 1'b0;
        st_d.e_inv     = 1'b0;
        if (in_valid) begin
            case (kind)
                K_HDR: begin
                    st_d.e_seq    = (st_q.state == S_BODY);
                    st_d.state    = S_BODY;
                    st_d.expect_n = hdr_count;
                    st_d.rcvd     = '0;
                end
                K_DATA: begin
                    if (st_q.state == S_BODY) begin
                        st_d.res_valid = 1'b1;
                        st_d.res_chan  = chan;
                        st_d.res_value = value;
                        st_d.res_ovf   = ovf;
                        st_d.res_unf   = unf;
                        if (st_q.rcvd != RCV_MAX) begin
                            st_d.rcvd = st_q.rcvd + 1'b1;
                        end
                    end else begin
                        st_d.e_seq = 1'b1;
                    end
                end
                K_FTR: begin
                    if (st_q.state == S_BODY) begin
                        st_d.done  = 1'b1;
                        st_d.evc   = evcount;
                        st_d.e_cnt = (st_q.rcvd != {1'b0, st_q.expect_n});
                        st_d.state = S_IDLE;
                    end else begin
                        st_d.e_seq = 1'b1;
                    end
                end
                K_INV: begin
                    st_d.e_inv = 1'b1;
                    st_d.state = S_IDLE;
                end
                default: begin
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign res_valid   = st_q.res_valid;
    assign res_chan    = st_q.res_chan;
    assign res_value   = st_q.res_value;
    assign res_ovf     = st_q.res_ovf;
    assign res_unf     = st_q.res_unf;
    assign evt_done    = st_q.done;
    assign evt_count   = st_q.evc;
    assign err_seq     = st_q.e_seq;
    assign err_count   = st_q.e_cnt;
    assign err_invalid = st_q.e_inv;
endmodule

// File: rtl/adc_evt_parser.sv
module adc_evt_parser
    import adc_evt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_word,
    output logic              res_valid,
    output logic [CH_W-1:0]   res_chan,
    output logic [VAL_W-1:0]  res_value,
    output logic              res_ovf,
    output logic              res_unf,
    output logic              evt_done,
    output logic [EVC_W-1:0]  evt_count,
    output logic              err_seq,
    output logic              err_count,
    output logic              err_invalid
);
    word_kind_t       w_kind;
    logic [CNT_W-1:0] w_cnt;
    logic [CH_W-1:0]  w_chan;
    logic [VAL_W-1:0] w_val;
    logic             w_ovf;
    logic             w_unf;
    logic [EVC_W-1:0] w_evc;

    adc_word_classify u_classify (
        .word      (in_word),
        .kind      (w_kind),
        .hdr_count (w_cnt),
        .chan      (w_chan),
        .value     (w_val),
        .ovf       (w_ovf),
        .unf       (w_unf),
        .evcount   (w_evc)
    );

    adc_evt_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .kind        (w_kind),
        .hdr_count   (w_cnt),
        .chan        (w_chan),
        .value       (w_val),
        .ovf         (w_ovf),
        .unf         (w_unf),
        .evcount     (w_evc),
        .res_valid   (res_valid),
        .res_chan    (res_chan),
        .res_value   (res_value),
        .res_ovf     (res_ovf),
        .res_unf     (res_unf),
        .evt_done    (evt_done),
        .evt_count   (evt_count),
        .err_seq     (err_seq),
        .err_count   (err_count),
        .err_invalid (err_invalid)
    );
endmodule

// File: rtl/adc_evt_parser_chk.sv
module adc_evt_parser_chk
    import adc_evt_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [WORD_W-1:0] in_word,
    input logic              res_valid,
    input logic [CH_W-1:0]   res_chan,
    input logic [VAL_W-1:0]  res_value,
    input logic              res_ovf,
    input logic              res_unf,
    input logic              evt_done,
    input logic [EVC_W-1:0]  evt_count,
    input logic              err_seq,
    input logic              err_count,
    input logic              err_invalid
);
    a_r3_result_from_data: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> ($past(in_valid) && $past(in_word[TYPE_LO +: TYPE_W]) == T_DATA));

    a_r3_result_value: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (res_value == $past(in_word[VAL_W-1:0])
                       && res_chan == $past(in_word[CH_LO +: CH_W])));

    a_r4_done_from_footer: assert property (@(posedge clk) disable iff (!rst_n)
        evt_done |-> ($past(in_valid) && $past(in_word[TYPE_LO +: TYPE_W]) == T_FTR
                      && evt_count == $past(in_word[EVC_W-1:0])));

    a_r5_seq_err_no_output: assert property (@(posedge clk) disable iff (!rst_n)
        err_seq |-> (!res_valid && !evt_done));

    a_r6_count_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        err_count |-> evt_done);

    a_r8_invalid_from_word: assert property (@(posedge clk) disable iff (!rst_n)
        err_invalid |-> ($past(in_valid) && $past(in_word[TYPE_LO +: TYPE_W]) == T_INV));

    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !(res_valid || evt_done || err_seq || err_count || err_invalid));

    a_r2_one_strobe_kind: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({res_valid, evt_done, err_seq, err_invalid}));
endmodule

bind adc_evt_parser adc_evt_parser_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_word     (in_word),
    .res_valid   (res_valid),
    .res_chan    (res_chan),
    .res_value   (res_value),
    .res_ovf     (res_ovf),
    .res_unf     (res_unf),
    .evt_done    (evt_done),
    .evt_count   (evt_count),
    .err_seq     (err_seq),
    .err_count   (err_count),
    .err_invalid (err_invalid)
);

// File: tb/adc_evt_parser_bench.sv
module adc_evt_parser_bench;
    localparam time CLK_P = 20ns;
    localparam logic [4:0] GEO = 5'h0A;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_word = '0;
    logic        res_valid, res_ovf, res_unf, evt_done, err_seq, err_count, err_invalid;
    logic [4:0]  res_chan;
    logic [11:0] res_value;
    logic [23:0] evt_count;

    int checks = 0;
    int errors = 0;

    always #(CLK_P/2) clk = ~clk;

    adc_evt_parser u_adc_evt_parser (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
        .res_valid(res_valid), .res_chan(res_chan), .res_value(res_value),
        .res_ovf(res_ovf), .res_unf(res_unf), .evt_done(evt_done),
        .evt_count(evt_count), .err_seq(err_seq), .err_count(err_count),
        .err_invalid(err_invalid)
    );

    function automatic logic [31:0] w_hdr(input int n);
        return {GEO, 3'b010, 8'h00, 2'b00, 6'(n), 8'h00};
    endfunction
    function automatic logic [31:0] w_dat(input int ch, input int v, input bit o, input bit u);
        return {GEO, 3'b000, 3'b000, 5'(ch), 2'b00, u, o, 12'(v)};
    endfunction
    function automatic logic [31:0] w_ftr(input int c);
        return {GEO, 3'b001, 24'(c)};
    endfunction
    function automatic logic [31:0] w_typ(input logic [2:0] t);
        return {GEO, t, 24'h5A5A5A};
    endfunction

    task automatic send(input logic [31:0] w);
        @(negedge clk);
        in_valid = 1'b1;
        in_word  = w;
        @(posedge clk);
        #2;
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
        @(posedge clk);
        #2;
    endtask

    // strobes = {res_valid, evt_done, err_seq, err_count, err_invalid}
    task automatic expect_out(input string tag, input logic [4:0] st,
                              input logic [19:0] res_f, input logic [23:0] evc);
        logic [4:0] act;
        act = {res_valid, evt_done, err_seq, err_count, err_invalid};
        checks++;
        if (act !== st) begin
            errors++;
            $display("FAIL %s strobes act=%b exp=%b", tag, act, st);
        end
        if (st[4]) begin
            checks++;
            if ({res_chan, res_unf, res_ovf, res_value} !== {res_f[19:15], res_f[13:12], res_f[11:0]}) begin
                errors++;
                $display("FAIL %s result act=%h exp=%h", tag,
                         {res_chan, res_unf, res_ovf, res_value},
                         {res_f[19:15], res_f[13:12], res_f[11:0]});
            end
        end
        if (st[3]) begin
            checks++;
            if (evt_count !== evc) begin
                errors++;
                $display("FAIL %s evt_count act=%h exp=%h", tag, evt_count, evc);
            end
        end
    endtask

    function automatic logic [19:0] rf(input int ch, input int v, input bit o, input bit u);
        return {5'(ch), 1'b0, u, o, 12'(v)};
    endfunction

    task automatic t_reset();
        #2;
        expect_out("R1 in reset", 5'b00000, '0, '0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #2;
        expect_out("R1 after reset", 5'b00000, '0, '0);
    endtask

    task automatic t_basic();
        send(w_hdr(3));                 expect_out("R2 header", 5'b00000, '0, '0);
        send(w_dat(5, 'h123, 0, 0));    expect_out("R3 data ch5", 5'b10000, rf(5, 'h123, 0, 0), '0);
        send(w_dat(31, 'hFFF, 1, 0));   expect_out("R3 data ovf", 5'b10000, rf(31, 'hFFF, 1, 0), '0);
        send(w_dat(0, 0, 0, 1));        expect_out("R3 data unf", 5'b10000, rf(0, 0, 0, 1), '0);
        send(w_ftr('hABC042));          expect_out("R4 footer", 5'b01000, '0, 24'hABC042);
    endtask

    task automatic t_gap();
        send(w_hdr(2));                 expect_out("R9 hdr", 5'b00000, '0, '0);
        send(w_dat(7, 'h055, 0, 0));    expect_out("R9 data1", 5'b10000, rf(7, 'h055, 0, 0), '0);
        idle();                         expect_out("R9 idle cycle", 5'b00000, '0, '0);
        send(w_dat(8, 'h0AA, 1, 1));    expect_out("R9 data2", 5'b10000, rf(8, 'h0AA, 1, 1), '0);
        send(w_ftr(1));                 expect_out("R9 footer", 5'b01000, '0, 24'd1);
    endtask

    task automatic t_orphan();
        send(w_dat(3, 'h111, 0, 0));    expect_out("R5 orphan data", 5'b00100, '0, '0);
        send(w_ftr(9));                 expect_out("R5 orphan footer", 5'b00100, '0, '0);
    endtask

    task automatic t_mismatch();
        send(w_hdr(2));                 expect_out("R6 hdr short", 5'b00000, '0, '0);
        send(w_dat(1, 1, 0, 0));        expect_out("R6 data", 5'b10000, rf(1, 1, 0, 0), '0);
        send(w_ftr(20));                expect_out("R6 too few", 5'b01010, '0, 24'd20);
        send(w_hdr(1));                 expect_out("R6 hdr long", 5'b00000, '0, '0);
        send(w_dat(2, 2, 0, 0));        expect_out("R6 data a", 5'b10000, rf(2, 2, 0, 0), '0);
        send(w_dat(3, 3, 0, 0));        expect_out("R6 data b", 5'b10000, rf(3, 3, 0, 0), '0);
        send(w_ftr(21));                expect_out("R6 too many", 5'b01010, '0, 24'd21);
    endtask

    task automatic t_rehdr();
        send(w_hdr(3));                 expect_out("R7 first hdr", 5'b00000, '0, '0);
        send(w_dat(4, 4, 0, 0));        expect_out("R7 stale data", 5'b10000, rf(4, 4, 0, 0), '0);
        send(w_hdr(1));                 expect_out("R7 second hdr", 5'b00100, '0, '0);
        send(w_dat(6, 6, 0, 0));        expect_out("R7 new data", 5'b10000, rf(6, 6, 0, 0), '0);
        send(w_ftr(30));                expect_out("R7 clean close", 5'b01000, '0, 24'd30);
    endtask

    task automatic t_invalid();
        send(w_hdr(2));                 expect_out("R8 hdr", 5'b00000, '0, '0);
        send(w_dat(9, 9, 0, 0));        expect_out("R8 data", 5'b10000, rf(9, 9, 0, 0), '0);
        send(w_typ(3'b110));            expect_out("R8 invalid", 5'b00001, '0, '0);
        send(w_ftr(31));                expect_out("R8 footer after abort", 5'b00100, '0, '0);
    endtask

    task automatic t_other();
        send(w_hdr(1));                 expect_out("R2 hdr", 5'b00000, '0, '0);
        send(w_typ(3'b011));            expect_out("R2 code 011 ignored", 5'b00000, '0, '0);
        send(w_typ(3'b111));            expect_out("R2 code 111 ignored", 5'b00000, '0, '0);
        send(w_dat(10, 'h7FF, 0, 0));   expect_out("R2 data", 5'b10000, rf(10, 'h7FF, 0, 0), '0);
        send(w_ftr(40));                expect_out("R2 event intact", 5'b01000, '0, 24'd40);
        send(w_typ(3'b100));            expect_out("R2 code 100 idle", 5'b00000, '0, '0);
    endtask

    task automatic t_bounds();
        send(w_hdr(0));                 expect_out("R10 hdr zero", 5'b00000, '0, '0);
        send(w_ftr(50));                expect_out("R10 zero close", 5'b01000, '0, 24'd50);
        send(w_hdr(63));                expect_out("R10 hdr max", 5'b00000, '0, '0);
        for (int i = 0; i < 63; i++) begin
            send(w_dat(i % 32, i * 65, 0, 0));
            expect_out("R10 max data", 5'b10000, rf(i % 32, i * 65, 0, 0), '0);
        end
        send(w_ftr('hFFFFFF));          expect_out("R10 max close", 5'b01000, '0, 24'hFFFFFF);
    endtask

    initial begin
        #(CLK_P * 100000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_basic();
        t_gap();
        t_orphan();
        t_mismatch();
        t_rehdr();
        t_invalid();
        t_other();
        t_bounds();
        idle();
        expect_out("R9 final idle", 5'b00000, '0, '0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule